// File: doc/BRIEF.md
# Bidirectional Port with Peripheral Pin Sharing

This block is a byte-sliced general purpose I/O port for a microcontroller. Each pin has an output latch bit and a direction bit. Both sit behind a small register bus. Any byte lane can be written on its own, either whole or through an 8-bit field mask. The block drives modelled pad signals, an output value and an output enable, and it samples the pad input through a two-stage synchronizer.

A peripheral can claim any pin through its alternate enable. On an ordinary pin, the alternate data is gated by the port latch, so the latch must hold 1 for the peripheral's data to pass. On pins marked as PWM outputs, the alternate data drives the pad directly. On pins built with automatic direction control, such as a multiplexed address/data bus, the peripheral's direction request replaces the software direction bit while it owns the pin.

Whenever a pin drives, the block loops its driven value back to the register read and to the alternate input. Software can therefore fire a peripheral input by writing the latch.

Top module: `gpio_altport`

## Requirements
- R1: After reset every direction bit is 0 (input), every latch bit is 0, and pad_oe is all zeros.
- R2: Writing the latch (bus_dir_sel=0) leaves the direction register and pad_oe unchanged, so the output level can be staged while the pin is still an input; with no alternate function the latch bit appears on pad_out.
- R3: A direction bit of 1 turns on pad_oe for that pin (when no automatic direction control applies), and a direction read (bus_dir_sel=1) returns the direction register.
- R4: For a pin whose pad_oe is 1, the data read (bus_dir_sel=0) and alt_in show the value the block itself drives on pad_out rather than the pad input.
- R5: A write with byte enable bus_be[h]=0 changes no bit in lane h (bits 8h+7..8h) of the addressed register.
- R6: With bus_mask_en=1, only the bits set in bus_mask (bit k of the mask selects bit k of each enabled lane) take the write data; the other bits keep their value.
- R7: For an input pin, pad_in reaches the data read and alt_in after exactly two rising clock edges.
- R8: On a pin with alt_en=1 that is not a PWM pin, pad_out equals the latch bit ANDed with alt_out.
- R9: On a pin listed in PWM_MASK with alt_en=1, pad_out equals alt_out regardless of the latch.
- R10: On a pin listed in AUTODIR_MASK, with both alt_en and alt_dir_en at 1, pad_oe follows alt_dir (1 = drive) instead of the direction register; on other pins alt_dir_en has no effect.
- R11: When alt_en=1 and automatic direction control is not active for the pin, pad_oe follows the software direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_dir_sel | input | 1 | 0 selects the latch/data register, 1 selects the direction register |
| bus_we | input | 1 | Write strobe |
| bus_be | input | WIDTH/8 | Byte lane enables |
| bus_mask_en | input | 1 | Use masked field write |
| bus_mask | input | 8 | Field mask applied to each enabled lane |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data: pin state or direction register |
| alt_en | input | WIDTH | Peripheral owns the pin |
| alt_out | input | WIDTH | Peripheral output data |
| alt_dir_en | input | WIDTH | Peripheral requests direction control |
| alt_dir | input | WIDTH | Peripheral direction request, 1 = drive |
| alt_in | output | WIDTH | Pin state delivered to the peripheral |
| pad_in | input | WIDTH | Pad input level |
| pad_out | output | WIDTH | Pad output value |
| pad_oe | output | WIDTH | Pad output enable |

## Verification
The bench builds the port 16 bits wide. It sets PWM_MASK to 16'h8001 and AUTODIR_MASK to 16'h0F00, so a single configuration contains ordinary, PWM and auto-direction pins side by side. With that mix, the PWM bypass shows on bit 15, where the latch holds 0. The hardware direction override shows on the middle nibble, next to lanes that keep following the software bit. The two 8-bit lanes also make it possible to check lane isolation and field-masked writes across a lane boundary.

// File: rtl/gpio_altport.sv
module gpio_altport #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] PWM_MASK = '0,
  parameter logic [WIDTH-1:0] AUTODIR_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_dir_sel,
  input  logic                 bus_we,
  input  logic [WIDTH/8-1:0]   bus_be,
  input  logic                 bus_mask_en,
  input  logic [7:0]           bus_mask,
  input  logic [WIDTH-1:0]     bus_wdata,
  output logic [WIDTH-1:0]     bus_rdata,
  input  logic [WIDTH-1:0]     alt_en,
  input  logic [WIDTH-1:0]     alt_out,
  input  logic [WIDTH-1:0]     alt_dir_en,
  input  logic [WIDTH-1:0]     alt_dir,
  output logic [WIDTH-1:0]     alt_in,
  input  logic [WIDTH-1:0]     pad_in,
  output logic [WIDTH-1:0]     pad_out,
  output logic [WIDTH-1:0]     pad_oe
);
  localparam int LANES = WIDTH / 8;

  logic [WIDTH-1:0] latch_q, dir_q, sync1_q, sync2_q;
  logic [WIDTH-1:0] hw_dir, eff_dir, alt_drv, pin_state;

  for (genvar h = 0; h < LANES; h++) begin : g_lane
    logic [7:0] lat_nx, dir_nx;
    assign lat_nx = bus_mask_en ? ((latch_q[h*8+:8] & ~bus_mask) | (bus_wdata[h*8+:8] & bus_mask))
                                : bus_wdata[h*8+:8];
    assign dir_nx = bus_mask_en ? ((dir_q[h*8+:8] & ~bus_mask) | (bus_wdata[h*8+:8] & bus_mask))
                                : bus_wdata[h*8+:8];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q[h*8+:8] <= '0;
        dir_q[h*8+:8]   <= '0;
      end else if (bus_we && bus_be[h]) begin
        if (bus_dir_sel) dir_q[h*8+:8]   <= dir_nx;
        else             latch_q[h*8+:8] <= lat_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign hw_dir    = alt_en & alt_dir_en & AUTODIR_MASK;
  assign eff_dir   = (hw_dir & alt_dir) | (~hw_dir & dir_q);
  assign alt_drv   = (PWM_MASK & alt_out) | (~PWM_MASK & alt_out & latch_q);
  assign pad_out   = (alt_en & alt_drv) | (~alt_en & latch_q);
  assign pad_oe    = eff_dir;
  assign pin_state = (eff_dir & pad_out) | (~eff_dir & sync2_q);
  assign alt_in    = pin_state;
  assign bus_rdata = bus_dir_sel ? dir_q : pin_state;
endmodule

module gpio_altport_chk #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] PWM_MASK = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_dir_sel,
  input logic               bus_we,
  input logic [WIDTH/8-1:0] bus_be,
  input logic               bus_mask_en,
  input logic [7:0]         bus_mask,
  input logic [WIDTH-1:0]   latch_q,
  input logic [WIDTH-1:0]   dir_q,
  input logic [WIDTH-1:0]   alt_en,
  input logic [WIDTH-1:0]   alt_out,
  input logic [WIDTH-1:0]   alt_dir_en,
  input logic [WIDTH-1:0]   alt_in,
  input logic [WIDTH-1:0]   pad_out,
  input logic [WIDTH-1:0]   pad_oe
);
  // R1
  reset_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '0));

  // R2
  latch_wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_dir_sel) |=> $stable(dir_q));

  // R4
  loopback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & (alt_in ^ pad_out)) == '0));

  // R8
  and_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((alt_en & ~PWM_MASK & ~latch_q & pad_out) == '0));

  for (genvar h = 0; h < WIDTH/8; h++) begin : g_lane_chk
    // R5
    lane_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_be[h]) |=> ($stable(latch_q[h*8+:8]) && $stable(dir_q[h*8+:8])));

    // R6
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_mask_en && !bus_dir_sel && bus_be[h]) |=>
        ((latch_q[h*8+:8] & ~$past(bus_mask)) == ($past(latch_q[h*8+:8]) & ~$past(bus_mask))));
  end
endmodule

bind gpio_altport gpio_altport_chk #(.WIDTH(WIDTH), .PWM_MASK(PWM_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_dir_sel(bus_dir_sel), .bus_we(bus_we),
  .bus_be(bus_be), .bus_mask_en(bus_mask_en), .bus_mask(bus_mask),
  .latch_q(latch_q), .dir_q(dir_q), .alt_en(alt_en), .alt_out(alt_out),
  .alt_dir_en(alt_dir_en), .alt_in(alt_in), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_altport_test.sv
module gpio_altport_test;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic bus_dir_sel = 0, bus_we = 0, bus_mask_en = 0;
  logic [1:0] bus_be = '0;
  logic [7:0] bus_mask = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [W-1:0] alt_en = '0, alt_out = '0, alt_dir_en = '0, alt_dir = '0, alt_in;
  logic [W-1:0] pad_in = '0, pad_out, pad_oe;

  always #2.5 clk = ~clk;

  gpio_altport #(.WIDTH(W), .PWM_MASK(16'h8001), .AUTODIR_MASK(16'h0F00)) uut (
    .clk(clk), .rst_n(rst_n), .bus_dir_sel(bus_dir_sel), .bus_we(bus_we),
    .bus_be(bus_be), .bus_mask_en(bus_mask_en), .bus_mask(bus_mask),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_en(alt_en),
    .alt_out(alt_out), .alt_dir_en(alt_dir_en), .alt_dir(alt_dir),
    .alt_in(alt_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct {
    int         kind;
    logic [W-1:0] exp;
    string      req;
  } item_t;

  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic expect_out(int kind, logic [W-1:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    #0.5;
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [W-1:0] got;
      it = sb.pop_front();
      case (it.kind)
        0: got = bus_rdata;
        1: got = pad_out;
        2: got = pad_oe;
        default: got = alt_in;
      endcase
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
      end
    end
  end

  task automatic wr(logic dsel, logic [1:0] be, logic men, logic [7:0] m, logic [W-1:0] d);
    @(posedge clk); #1;
    bus_dir_sel = dsel; bus_be = be; bus_mask_en = men; bus_mask = m; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1;
    bus_we = 0; bus_mask_en = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    bus_dir_sel = 1; expect_out(0, 16'h0000, "R1"); expect_out(2, 16'h0000, "R1");
    expect_out(1, 16'h0000, "R1"); drain();

    // R2 stage latch while input
    wr(0, 2'b11, 0, 8'h00, 16'hA5C3);
    expect_out(2, 16'h0000, "R2"); expect_out(1, 16'hA5C3, "R2");
    bus_dir_sel = 1; drain(); expect_out(0, 16'h0000, "R2"); drain();

    // R3 / R4 drive on, loopback
    wr(1, 2'b11, 0, 8'h00, 16'hFFFF);
    expect_out(2, 16'hFFFF, "R3"); drain();
    bus_dir_sel = 1; drain(); expect_out(0, 16'hFFFF, "R3"); drain();
    bus_dir_sel = 0; drain(); expect_out(0, 16'hA5C3, "R4"); expect_out(3, 16'hA5C3, "R4"); drain();

    // R5 lane isolation
    wr(0, 2'b01, 0, 8'h00, 16'h1234);
    expect_out(1, 16'hA534, "R5"); drain();
    wr(0, 2'b10, 0, 8'h00, 16'h7700);
    expect_out(1, 16'h7734, "R5"); drain();

    // R6 masked field write
    wr(0, 2'b11, 1, 8'h0F, 16'hFFFF);
    expect_out(1, 16'h7F3F, "R6"); drain();
    wr(0, 2'b01, 1, 8'h30, 16'h0000);
    expect_out(1, 16'h7F0F, "R6"); drain();
    wr(0, 2'b01, 1, 8'h30, 16'hFFFF);
    expect_out(1, 16'h7F3F, "R6"); drain();

    // R8 / R9 alternate output
    alt_en = 16'hFFFF; alt_out = 16'hF0F0;
    drain(); expect_out(1, 16'hF030, "R8 R9"); expect_out(3, 16'hF030, "R4"); drain();
    alt_out = 16'h0000; drain(); expect_out(1, 16'h0000, "R9"); drain();

    // R10 automatic direction
    alt_dir_en = 16'hFFFF; alt_dir = 16'h0000;
    drain(); expect_out(2, 16'hF0FF, "R10"); drain();
    alt_dir = 16'h0300;
    drain(); expect_out(2, 16'hF3FF, "R10"); drain();
    alt_en = 16'h0000;
    drain(); expect_out(2, 16'hFFFF, "R10"); drain();

    // R11 alternate without direction control
    alt_en = 16'hFFFF; alt_dir_en = 16'h0000;
    wr(1, 2'b11, 0, 8'h00, 16'h00FF);
    expect_out(2, 16'h00FF, "R11"); drain();

    // R7 synchronizer latency
    alt_en = '0;
    wr(1, 2'b11, 0, 8'h00, 16'h0000);
    bus_dir_sel = 0; pad_in = 16'h3C3C;
    @(posedge clk); expect_out(0, 16'h0000, "R7"); drain();
    @(posedge clk); expect_out(0, 16'h3C3C, "R7"); expect_out(3, 16'h3C3C, "R7"); drain();

    drain();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule